// File: doc/BRIEF.md
# Reset Configuration Control Register

This block is a single control register that sets how the chip's reset sources behave. It holds four enables: the low-voltage reset enable, the low-voltage detector enable, the clock-stop reset enable and a select for the main-clock stop-check interval. Each field comes out of reset in a way that depends on the kind of reset that occurred. Power-on and external resets restore the low-voltage fields. Any reset clears the clock-stop fields.

Software writes the whole register through a single-cycle write strobe. The block blocks some writes in hardware:

- The clock-stop reset enable changes only while system clock 1 runs from the RC oscillator.
- The detector enable cannot be dropped while the low-voltage reset is armed.
- The low-voltage reset can only be armed once the detector is on and reports that it has settled.

A persistent mode-pin code forces the effective low-voltage enables on, whatever the register holds. The register itself and its readback are not changed by this code.

Top module: `rst_cfg_ctrl`

## Requirements
- R1: After the asynchronous reset, rd_data_o reads 8'h06: bit1 (low-voltage reset enable) = 1, bit2 (detector enable) = 1, bit3 (clock-stop reset enable) = 0, bit4 (interval select) = 0. Bits 0 and 7:5 always read 0, even after a write of 1s to them.
- R2: A power-on pulse (pwr_rst_i) or an external pulse (ext_rst_i) sets bit1 and bit2 to 1 at the next clock edge.
- R3: A pulse on oth_rst_i leaves bit1 and bit2 unchanged.
- R4: Any reset pulse clears bit3 and bit4 at the next edge. A write in the same cycle as a reset pulse is ignored.
- R5: A write always loads bit4. It loads bit3 only when clk1_src_i = 2'b00 (RC). For the codes 2'b01 (main), 2'b10 (PLL) and 2'b11 (sub), bit3 keeps its value.
- R6: A write that clears bit2 while bit1 currently holds 1 leaves bit2 at 1. A write that clears bit1 is always accepted.
- R7: A write that sets bit1 while bit1 is 0 takes effect only if det_ready_i is 1 and bit2 is 1 after that same write. Otherwise bit1 stays 0.
- R8: When mode_i = 3'b011, lv_rst_en_o and lv_det_en_o are 1. Under any other code they equal bit1 and bit2. The mode code never changes rd_data_o.
- R9: cs_rst_en_o equals bit3, and mcs_intv_short_o equals bit4 (1 selects the short stop-check interval).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, gives power-on values |
| pwr_rst_i | input | 1 | Power-on reset kind pulse, synchronous |
| ext_rst_i | input | 1 | External reset kind pulse, synchronous |
| oth_rst_i | input | 1 | Any other reset kind pulse, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| clk1_src_i | input | 2 | System clock 1 source: 00 RC, 01 main, 10 PLL, 11 sub |
| mode_i | input | 3 | Mode pin code |
| det_ready_i | input | 1 | Low-voltage detector has settled |
| rd_data_o | output | 8 | Register readback |
| lv_rst_en_o | output | 1 | Effective low-voltage reset enable |
| lv_det_en_o | output | 1 | Effective low-voltage detector enable |
| cs_rst_en_o | output | 1 | Clock-stop reset enable |
| mcs_intv_short_o | output | 1 | Short main-clock stop-check interval select |

## Verification
The assertions assume that at most one of the three reset-kind pulses is high in any cycle. The block gives the power-on and external kinds priority over the other kind but does not check for overlap. The interlock assertions also assume that det_ready_i is a plain level, sampled in the cycle of the write. The directed part of the stimulus raises one reset kind at a time. The random phase draws one reset kind from a single number, so it never produces overlapping pulses. Neither part relies on any ordering of det_ready_i beyond that.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_LVR = 1;
  localparam int BIT_LVD = 2;
  localparam int BIT_CSR = 3;
  localparam int BIT_MCI = 4;

  typedef enum logic [1:0] {
    CLK_RC   = 2'b00,
    CLK_MAIN = 2'b01,
    CLK_PLL  = 2'b10,
    CLK_SUB  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/rcfg_lv_ctrl.sv
module rcfg_lv_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic soft_rst_i,
  input  logic wr_en_i,
  input  logic wr_rst_i,
  input  logic wr_det_i,
  input  logic det_ready_i,
  output logic lv_rst_q_o,
  output logic lv_det_q_o
);
  logic rst_q, det_q, rst_d, det_d;

  always_comb begin
    rst_d = rst_q;
    det_d = det_q;
    if (hard_rst_i) begin
      rst_d = 1'b1;
      det_d = 1'b1;
    end else if (soft_rst_i) begin
      rst_d = rst_q;
      det_d = det_q;
    end else if (wr_en_i) begin
      // detector may not drop while reset is armed
      det_d = wr_det_i | rst_q;
      if (!wr_rst_i)   rst_d = 1'b0;
      else if (!rst_q) rst_d = det_d & det_ready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b1;
      det_q <= 1'b1;
    end else begin
      rst_q <= rst_d;
      det_q <= det_d;
    end
  end

  assign lv_rst_q_o = rst_q;
  assign lv_det_q_o = det_q;

  assert_hard_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (rst_q && det_q));
  assert_soft_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !hard_rst_i) |=> ($stable(rst_q) && $stable(det_q)));
  assert_interlock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> det_q);
  assert_arm_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> ($past(det_ready_i) || $past(hard_rst_i)));
endmodule

// File: rtl/rcfg_cs_ctrl.sv
module rcfg_cs_ctrl
  import rcfg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     any_rst_i,
  input  logic     wr_en_i,
  input  clk_src_e clk_src_i,
  input  logic     wr_cs_i,
  input  logic     wr_intv_i,
  output logic     cs_q_o,
  output logic     intv_q_o
);
  logic cs_q, intv_q;
  logic cs_wr_ok;

  assign cs_wr_ok = wr_en_i && (clk_src_i == CLK_RC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      intv_q <= 1'b0;
    end else if (any_rst_i) begin
      cs_q   <= 1'b0;
      intv_q <= 1'b0;
    end else begin
      if (cs_wr_ok) cs_q   <= wr_cs_i;
      if (wr_en_i)  intv_q <= wr_intv_i;
    end
  end

  assign cs_q_o   = cs_q;
  assign intv_q_o = intv_q;

  assert_rst_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst_i |=> (!cs_q && !intv_q));
  assert_cs_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_rst_i && clk_src_i != CLK_RC) |=> $stable(cs_q));
  assert_intv_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_rst_i) |=> (intv_q == $past(wr_intv_i)));
endmodule

// File: rtl/rst_cfg_ctrl.sv
module rst_cfg_ctrl
  import rcfg_pkg::*;
#(
  parameter int              MODE_W       = 3,
  parameter logic [MODE_W-1:0] PERSIST_MODE = 3'b011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_rst_i,
  input  logic              ext_rst_i,
  input  logic              oth_rst_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [1:0]        clk1_src_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              det_ready_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              lv_rst_en_o,
  output logic              lv_det_en_o,
  output logic              cs_rst_en_o,
  output logic              mcs_intv_short_o
);
  logic hard_rst, any_rst, persist;
  logic lvr_q, lvd_q, csr_q, mci_q;
  logic unused_wr_bits;

  assign hard_rst = pwr_rst_i | ext_rst_i;
  assign any_rst  = hard_rst | oth_rst_i;
  assign persist  = (mode_i == PERSIST_MODE);
  assign unused_wr_bits = ^{wr_data_i[0], wr_data_i[REG_W-1:BIT_MCI+1]};

  rcfg_lv_ctrl u_lv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hard_rst_i  (hard_rst),
    .soft_rst_i  (oth_rst_i),
    .wr_en_i     (wr_en_i),
    .wr_rst_i    (wr_data_i[BIT_LVR]),
    .wr_det_i    (wr_data_i[BIT_LVD]),
    .det_ready_i (det_ready_i),
    .lv_rst_q_o  (lvr_q),
    .lv_det_q_o  (lvd_q)
  );

  rcfg_cs_ctrl u_cs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_rst_i (any_rst),
    .wr_en_i   (wr_en_i),
    .clk_src_i (clk_src_e'(clk1_src_i)),
    .wr_cs_i   (wr_data_i[BIT_CSR]),
    .wr_intv_i (wr_data_i[BIT_MCI]),
    .cs_q_o    (csr_q),
    .intv_q_o  (mci_q)
  );

  always_comb begin
    rd_data_o          = '0;
    rd_data_o[BIT_LVR] = lvr_q;
    rd_data_o[BIT_LVD] = lvd_q;
    rd_data_o[BIT_CSR] = csr_q;
    rd_data_o[BIT_MCI] = mci_q;
  end

  assign lv_rst_en_o      = lvr_q | persist;
  assign lv_det_en_o      = lvd_q | persist;
  assign cs_rst_en_o      = csr_q;
  assign mcs_intv_short_o = mci_q;

  assert_persist_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PERSIST_MODE) |-> (lv_rst_en_o && lv_det_en_o));
  assert_unused_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[0] == 1'b0) && (rd_data_o[REG_W-1:BIT_MCI+1] == '0));
  assert_write_lv_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_rst && !wr_data_i[BIT_LVR]) |=> !rd_data_o[BIT_LVR]);
endmodule

// File: tb/rst_cfg_ctrl_tb_top.sv
module rst_cfg_ctrl_tb_top;
  localparam time CLK_P = 20ns;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       pwr_rst_i, ext_rst_i, oth_rst_i, wr_en_i, det_ready_i;
  logic [7:0] wr_data_i;
  logic [1:0] clk1_src_i;
  logic [2:0] mode_i;
  logic [7:0] rd_data_o;
  logic       lv_rst_en_o, lv_det_en_o, cs_rst_en_o, mcs_intv_short_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  bit m_lvr, m_lvd, m_cs, m_mi;

  always #(CLK_P/2) clk_i = ~clk_i;

  rst_cfg_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pwr_rst_i(pwr_rst_i), .ext_rst_i(ext_rst_i), .oth_rst_i(oth_rst_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .clk1_src_i(clk1_src_i),
    .mode_i(mode_i), .det_ready_i(det_ready_i),
    .rd_data_o(rd_data_o), .lv_rst_en_o(lv_rst_en_o), .lv_det_en_o(lv_det_en_o),
    .cs_rst_en_o(cs_rst_en_o), .mcs_intv_short_o(mcs_intv_short_o)
  );

  function automatic logic [11:0] expect_vec();
    bit f = (mode_i == 3'b011);
    logic [7:0] rd = {3'b000, m_mi, m_cs, m_lvd, m_lvr, 1'b0};
    return {rd, m_lvr | f, m_lvd | f, m_cs, m_mi};
  endfunction

  task automatic compare(input string tag);
    logic [11:0] act = {rd_data_o, lv_rst_en_o, lv_det_en_o, cs_rst_en_o, mcs_intv_short_o};
    logic [11:0] exp = expect_vec();
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit pw, input bit ex, input bit ot, input bit we,
                            input logic [7:0] wd, input logic [1:0] sel, input bit rdy);
    bit nd;
    if (pw || ex) begin
      m_lvr = 1; m_lvd = 1; m_cs = 0; m_mi = 0;
    end else if (ot) begin
      m_cs = 0; m_mi = 0;
    end else if (we) begin
      m_mi = wd[4];
      if (sel == 2'b00) m_cs = wd[3];
      nd = wd[2] || m_lvr;
      if (!wd[1])      m_lvr = 0;
      else if (!m_lvr) m_lvr = nd && rdy;
      m_lvd = nd;
    end
  endtask

  task automatic step(input bit pw, input bit ex, input bit ot, input bit we,
                      input logic [7:0] wd, input logic [1:0] sel, input logic [2:0] md,
                      input bit rdy, input string tag);
    pwr_rst_i = pw; ext_rst_i = ex; oth_rst_i = ot; wr_en_i = we; wr_data_i = wd;
    clk1_src_i = sel; mode_i = md; det_ready_i = rdy;
    @(posedge clk_i);
    model_edge(pw, ex, ot, we, wd, sel, rdy);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic wr(input logic [7:0] wd, input logic [1:0] sel, input bit rdy, input string tag);
    step(0, 0, 0, 1, wd, sel, 3'b000, rdy, tag);
  endtask

  task automatic idle(input logic [2:0] md, input string tag);
    step(0, 0, 0, 0, 8'h00, 2'b00, md, 1, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 0; pwr_rst_i = 0; ext_rst_i = 0; oth_rst_i = 0; wr_en_i = 0;
    wr_data_i = 0; clk1_src_i = 0; mode_i = 0; det_ready_i = 1;
    m_lvr = 1; m_lvd = 1; m_cs = 0; m_mi = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    compare("R1 reset value");
    idle(3'b000, "R1 hold");

    wr(8'h1E, 2'b00, 1, "R5 write all on RC");
    wr(8'h06, 2'b01, 1, "R5 cs gated main");
    wr(8'h06, 2'b10, 1, "R5 cs gated pll");
    wr(8'h16, 2'b11, 1, "R5 cs gated sub, R9");
    wr(8'h06, 2'b00, 1, "R5 cs clear on RC");
    wr(8'h02, 2'b00, 1, "R6 det clear blocked");
    wr(8'h00, 2'b00, 1, "R6 rst clear det held");
    wr(8'h00, 2'b00, 1, "R6 det clear now ok");
    wr(8'h02, 2'b00, 1, "R7 arm with det off");
    wr(8'h06, 2'b00, 0, "R7 arm not ready");
    wr(8'h06, 2'b00, 1, "R7 arm ready");
    wr(8'h00, 2'b00, 1, "R7 disarm");
    wr(8'h00, 2'b00, 1, "R8 clear det");
    idle(3'b011, "R8 persist forces");
    idle(3'b010, "R8 other mode");
    wr(8'h18, 2'b00, 1, "R9 cs and interval");
    step(0, 0, 1, 1, 8'h06, 2'b00, 3'b000, 1, "R3 R4 other rst wins");
    wr(8'h18, 2'b00, 1, "R4 set again");
    step(1, 0, 0, 0, 8'h00, 2'b00, 3'b000, 1, "R2 power pulse");
    wr(8'h00, 2'b00, 1, "R2 clear rst");
    wr(8'h00, 2'b00, 1, "R2 clear det");
    step(0, 1, 0, 0, 8'h00, 2'b00, 3'b000, 1, "R2 ext pulse");
    step(0, 0, 1, 0, 8'h00, 2'b00, 3'b000, 1, "R3 other keeps lv");
    wr(8'hFF, 2'b00, 1, "R1 unused bits zero");

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 19);
      step(k == 0, k == 1, k == 2, k > 4, 8'($urandom), 2'($urandom),
           ($urandom_range(0, 3) == 0) ? 3'b011 : 3'($urandom),
           $urandom_range(0, 2) != 0, "R5 R6 R7 R8 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule